// File: doc/BRIEF.md
# Multiplexed SAR Converter Serial Slave Controller

This block is the digital side of an eight-input successive-approximation converter, written as a synthesizable slave. It runs in the system clock domain and samples three host lines: a convert/select strobe, a shift clock and a serial data input. A rising convert strobe starts a fixed-length conversion timer. When the timer expires, the block loads the word on `sample_i` into an output shift register and marks the load with a one-cycle `done_o` pulse. `sample_i` stands in for the analog core's result. The serial output comes out as a data bit and a separate drive enable, so the pad can be built around it.

While the strobe is low, the host reads the previous result, most significant bit first, and at the same time shifts in a 7-bit setup word. That word picks the input pair, the polarity mode and the power request for the next conversion. It is applied on the rising strobe that ends the frame. The block decodes the word into a positive channel, a negative channel or ground, and a unipolar flag. It refuses any combination the multiplexer cannot build. It also tracks power: active, nap (after a conversion that ends with the strobe still high), sleep (requested by the word), and a wake-up interval after sleep.

Top module: `adc_serial_slave`

## Requirements
- R1: Reset sets: power state active (`pwr_o` = 0), `busy_o` = 0, `done_o` = 0, `sdo_oe_o` = 0, `pos_ch_o` = 0, `neg_ch_o` = 1, `neg_gnd_o` = 0, `unipolar_o` = 0, `cfg_err_o` = 0. A convert line held high through reset does not start a conversion.
- R2: A rising convert edge seen in the active state starts a conversion: `busy_o` is 1 from the next cycle. `done_o` pulses for exactly one cycle, CONV_CYCLES clock edges after the edge that saw the rise.
- R3: Rising convert edges seen during a conversion are ignored. They neither restart nor lengthen it, and they give no extra `done_o`.
- R4: If the convert line is high when a conversion ends, the block enters nap (`pwr_o` = 1) with SDO undriven. The first clock edge that sees the line low returns it to active and enables SDO.
- R5: If the convert line is low when a conversion ends, SDO is enabled and shows the result MSB in the same cycle as `done_o`, and the state stays active.
- R6: `sdo_oe_o` is 0 in the cycle after any cycle in which the convert line was high, and during a conversion or wake-up. While enabled, `sdo_o` is the result MSB first. Each falling shift-clock edge advances it by one bit, and zeros follow the LSB.
- R7: The setup word is taken on rising shift-clock edges, first bit first. Its order is: single-ended, odd/sign, select1, select0, common-return, unipolar, sleep. Only the first 7 bits of a frame count. A frame with fewer than 7 bits changes nothing. Decoded outputs change on the edge that sees the next rising convert, not before.
- R8: With single-ended = 0 and common-return = 0, the pair is {2·sel, 2·sel+1}. The positive input is 2·sel+odd, the negative is the other one of the pair, and `neg_gnd_o` = 0.
- R9: With single-ended = 1, the positive input is 2·sel+odd. With common-return = 0 the negative is ground (`neg_gnd_o` = 1, `neg_ch_o` = 0). With common-return = 1 the negative is channel 7 (`neg_gnd_o` = 0).
- R10: Two words are illegal: common-return = 1 with single-ended = 0, and common-return = 1 with positive channel 7. Either one pulses `cfg_err_o` for one cycle and leaves all decoded outputs unchanged, and the conversion still runs.
- R11: A legal complete word with sleep = 1, applied at a rising convert, enters sleep (`pwr_o` = 2) and starts no conversion. A rising convert with a partial word, or with another sleep word, keeps the block in sleep.
- R12: In sleep, a legal complete word with sleep = 0, applied at a rising convert, enters wake-up (`pwr_o` = 3) for WAKE_CYCLES edges. Rising edges during wake-up are ignored. Wake-up then ends in nap if the line is high, or in active if it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Convert strobe and frame select (frame while low) |
| sck_i | input | 1 | Serial shift clock, sampled by clk |
| sdi_i | input | 1 | Serial setup word input |
| sample_i | input | RES_BITS | Result from the analog core |
| sdo_o | output | 1 | Serial result data |
| sdo_oe_o | output | 1 | Drive enable for the serial output |
| done_o | output | 1 | One-cycle pulse when the result is loaded |
| busy_o | output | 1 | Conversion in progress |
| pwr_o | output | 2 | Power state: 0 active, 1 nap, 2 sleep, 3 waking |
| pos_ch_o | output | 3 | Positive input channel |
| neg_ch_o | output | 3 | Negative input channel (0 when ground) |
| neg_gnd_o | output | 1 | Negative input is ground |
| unipolar_o | output | 1 | Unipolar conversion mode |
| cfg_err_o | output | 1 | Pulse: illegal setup word rejected |

## Verification
The decoded channel outputs, `cfg_err_o`, `busy_o` and the sleep or wake state are due one clock edge after the edge that first sees the convert line high. `done_o` is due CONV_CYCLES edges after that edge, and the nap-or-active decision and the MSB land in the same cycle as `done_o`. The SDO enable follows a falling convert line by one edge, and each falling shift-clock edge moves the data by one bit on the next clock edge. The bench drives all inputs on the falling clock edge and counts falling edges from the one where it raised the line. It samples `done_o` both one cycle early (expecting 0) and on time (expecting 1), so an off-by-one in either timer shows up. The wake-up interval is checked the same way, at its last waking cycle and at its first cycle after.

// File: rtl/adc_slave_pkg.sv
package adc_slave_pkg;

  localparam int CFG_BITS = 7;
  localparam int CH_W     = 3;
  localparam logic [CH_W-1:0] COM_CH = 3'd7;

  // bit positions inside the received setup word (first shifted bit is MSB)
  localparam int B_SD  = 6;
  localparam int B_OS  = 5;
  localparam int B_S1  = 4;
  localparam int B_S0  = 3;
  localparam int B_COM = 2;
  localparam int B_UNI = 1;
  localparam int B_SLP = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_NAP,
    ST_SLEEP,
    ST_WAKE
  } ctl_state_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2,
    PWR_WAKE   = 2'd3
  } pwr_e;

  typedef struct packed {
    logic [CH_W-1:0] pos;
    logic [CH_W-1:0] neg;
    logic            neg_gnd;
    logic            unipolar;
  } mux_cfg_t;

  localparam mux_cfg_t CFG_RESET = '{pos: 3'd0, neg: 3'd1, neg_gnd: 1'b0, unipolar: 1'b0};

endpackage

// File: rtl/adc_cfg_decode.sv
module adc_cfg_decode
  import adc_slave_pkg::*;
(
  input  logic [CFG_BITS-1:0] word_i,
  output mux_cfg_t            cfg_o,
  output logic                valid_o
);

  logic [1:0] sel;

  always_comb begin
    sel              = {word_i[B_S1], word_i[B_S0]};
    cfg_o            = '0;
    valid_o          = 1'b1;
    cfg_o.unipolar   = word_i[B_UNI];
    cfg_o.pos        = {sel, word_i[B_OS]};
    if (!word_i[B_SD]) begin
      // pair mode: odd/sign picks which member of the pair is positive
      cfg_o.neg     = {sel, ~word_i[B_OS]};
      cfg_o.neg_gnd = 1'b0;
      if (word_i[B_COM]) valid_o = 1'b0;
    end else if (word_i[B_COM]) begin
      cfg_o.neg     = COM_CH;
      cfg_o.neg_gnd = 1'b0;
      if (cfg_o.pos == COM_CH) valid_o = 1'b0;
    end else begin
      cfg_o.neg     = '0;
      cfg_o.neg_gnd = 1'b1;
    end
  end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_slave_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_i,
  input  logic                sdi_i,
  input  logic                port_en_i,
  input  logic                frame_clr_i,
  input  logic                load_i,
  input  logic [RES_BITS-1:0] load_data_i,
  output logic                sdo_o,
  output logic [CFG_BITS-1:0] word_o,
  output logic                word_full_o
);

  localparam int BCNT_W = $clog2(CFG_BITS + 1);
  localparam logic [BCNT_W-1:0] BCNT_FULL = BCNT_W'(CFG_BITS);

  logic                sck_q;
  logic                sck_rise;
  logic                sck_fall;
  logic [BCNT_W-1:0]   bcnt;
  logic [RES_BITS-1:0] data_sh;

  assign sck_rise = sck_i & ~sck_q & port_en_i;
  assign sck_fall = ~sck_i & sck_q & port_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      bcnt   <= '0;
      word_o <= '0;
    end else begin
      sck_q <= sck_i;
      if (frame_clr_i) begin
        bcnt <= '0;
      end else if (sck_rise && (bcnt < BCNT_FULL)) begin
        word_o <= {word_o[CFG_BITS-2:0], sdi_i};
        bcnt   <= bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_sh <= '0;
    end else if (load_i) begin
      data_sh <= load_data_i;
    end else if (sck_fall) begin
      data_sh <= {data_sh[RES_BITS-2:0], 1'b0};
    end
  end

  assign sdo_o       = data_sh[RES_BITS-1];
  assign word_full_o = (bcnt == BCNT_FULL);

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_slave_pkg::*;
#(
  parameter int CONV_CYCLES = 400,
  parameter int WAKE_CYCLES = 7_500_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnv_i,
  input  logic       word_full_i,
  input  logic       word_valid_i,
  input  logic       word_sleep_i,
  output logic       commit_o,
  output logic       load_o,
  output logic       frame_clr_o,
  output logic       oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] pwr_o,
  output logic       cfg_err_o
);

  localparam int MAXC  = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);

  ctl_state_e       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             cnv_q;
  logic             cnv_rise;
  logic             err_n;
  pwr_e             pwr_n;

  assign cnv_rise    = cnv_i & ~cnv_q;
  assign frame_clr_o = cnv_rise;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    commit_o = 1'b0;
    load_o   = 1'b0;
    err_n    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (cnv_rise) begin
          st_n  = ST_CONV;
          cnt_n = CONV_LAST;
          if (word_full_i) begin
            if (word_valid_i) begin
              commit_o = 1'b1;
              if (word_sleep_i) begin
                st_n  = ST_SLEEP;
                cnt_n = '0;
              end
            end else begin
              err_n = 1'b1;
            end
          end
        end
      end
      ST_CONV: begin
        if (cnt == '0) begin
          load_o = 1'b1;
          st_n   = cnv_i ? ST_NAP : ST_IDLE;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_NAP: begin
        if (!cnv_i) st_n = ST_IDLE;
      end
      ST_SLEEP: begin
        if (cnv_rise && word_full_i) begin
          if (word_valid_i) begin
            commit_o = 1'b1;
            if (!word_sleep_i) begin
              st_n  = ST_WAKE;
              cnt_n = WAKE_LAST;
            end
          end else begin
            err_n = 1'b1;
          end
        end
      end
      ST_WAKE: begin
        if (cnt == '0) begin
          st_n = cnv_i ? ST_NAP : ST_IDLE;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_n)
      ST_NAP:   pwr_n = PWR_NAP;
      ST_SLEEP: pwr_n = PWR_SLEEP;
      ST_WAKE:  pwr_n = PWR_WAKE;
      default:  pwr_n = PWR_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      cnv_q     <= 1'b1;
      oe_o      <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      pwr_o     <= PWR_ACTIVE;
      cfg_err_o <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      cnv_q     <= cnv_i;
      oe_o      <= ~cnv_i & ((st_n == ST_IDLE) | (st_n == ST_SLEEP));
      busy_o    <= (st_n == ST_CONV);
      done_o    <= load_o;
      pwr_o     <= pwr_n;
      cfg_err_o <= err_n;
    end
  end

endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adc_slave_pkg::*;
#(
  parameter int RES_BITS    = 16,
  parameter int CONV_CYCLES = 400,
  parameter int WAKE_CYCLES = 7_500_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnv_i,
  input  logic                sck_i,
  input  logic                sdi_i,
  input  logic [RES_BITS-1:0] sample_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic                done_o,
  output logic                busy_o,
  output logic [1:0]          pwr_o,
  output logic [CH_W-1:0]     pos_ch_o,
  output logic [CH_W-1:0]     neg_ch_o,
  output logic                neg_gnd_o,
  output logic                unipolar_o,
  output logic                cfg_err_o
);

  logic [CFG_BITS-1:0] word;
  logic                word_full;
  mux_cfg_t            dec_cfg;
  mux_cfg_t            cfg_q;
  logic                dec_valid;
  logic                commit;
  logic                load;
  logic                frame_clr;

  adc_serial_port #(.RES_BITS(RES_BITS)) u_port (
    .clk         (clk),
    .rst         (rst),
    .sck_i       (sck_i),
    .sdi_i       (sdi_i),
    .port_en_i   (sdo_oe_o),
    .frame_clr_i (frame_clr),
    .load_i      (load),
    .load_data_i (sample_i),
    .sdo_o       (sdo_o),
    .word_o      (word),
    .word_full_o (word_full)
  );

  adc_cfg_decode u_dec (
    .word_i  (word),
    .cfg_o   (dec_cfg),
    .valid_o (dec_valid)
  );

  adc_conv_ctrl #(
    .CONV_CYCLES (CONV_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cnv_i        (cnv_i),
    .word_full_i  (word_full),
    .word_valid_i (dec_valid),
    .word_sleep_i (word[B_SLP]),
    .commit_o     (commit),
    .load_o       (load),
    .frame_clr_o  (frame_clr),
    .oe_o         (sdo_oe_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pwr_o        (pwr_o),
    .cfg_err_o    (cfg_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (commit) begin
      cfg_q <= dec_cfg;
    end
  end

  assign pos_ch_o   = cfg_q.pos;
  assign neg_ch_o   = cfg_q.neg;
  assign neg_gnd_o  = cfg_q.neg_gnd;
  assign unipolar_o = cfg_q.unipolar;

endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       cnv_i,
  input logic       sdo_oe_o,
  input logic       done_o,
  input logic       busy_o,
  input logic [1:0] pwr_o,
  input logic [2:0] pos_ch_o,
  input logic [2:0] neg_ch_o,
  input logic       neg_gnd_o,
  input logic       unipolar_o,
  input logic       cfg_err_o
);

  AST_HIZ_AFTER_CNV_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(cnv_i) |-> !sdo_oe_o); // R6

  AST_NO_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !sdo_oe_o); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R2

  AST_NAP_ON_HIGH_END: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(cnv_i)) |-> (pwr_o == 2'd1 && !sdo_oe_o)); // R4

  AST_ACTIVE_ON_LOW_END: assert property (@(posedge clk) disable iff (rst)
    (done_o && !$past(cnv_i)) |-> (pwr_o == 2'd0 && sdo_oe_o)); // R5

  AST_ERR_KEEPS_MUX: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> $stable({pos_ch_o, neg_ch_o, neg_gnd_o, unipolar_o})); // R10

  AST_MUX_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !neg_gnd_o |-> (((pos_ch_o ^ neg_ch_o) == 3'd1) ||
                    (neg_ch_o == 3'd7 && pos_ch_o != 3'd7))); // R9

  AST_SLEEP_NO_CONV: assert property (@(posedge clk) disable iff (rst)
    (pwr_o == 2'd2 || pwr_o == 2'd3) |-> (!busy_o && !done_o)); // R11

endmodule

bind adc_serial_slave adc_serial_slave_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnv_i      (cnv_i),
  .sdo_oe_o   (sdo_oe_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .pwr_o      (pwr_o),
  .pos_ch_o   (pos_ch_o),
  .neg_ch_o   (neg_ch_o),
  .neg_gnd_o  (neg_gnd_o),
  .unipolar_o (unipolar_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/tb_adc_serial_slave.sv
module tb_adc_serial_slave;

  localparam int RES  = 16;
  localparam int CONV = 20;
  localparam int WAKE = 50;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst, cnv, sck, sdi;
  logic [RES-1:0] sample;
  logic           sdo, oe, done, busy, gnd, uni, cfg_err;
  logic [1:0]     pwr;
  logic [2:0]     pos, neg;

  adc_serial_slave #(.RES_BITS(RES), .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rst(rst), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi), .sample_i(sample),
    .sdo_o(sdo), .sdo_oe_o(oe), .done_o(done), .busy_o(busy), .pwr_o(pwr),
    .pos_ch_o(pos), .neg_ch_o(neg), .neg_gnd_o(gnd), .unipolar_o(uni), .cfg_err_o(cfg_err)
  );

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  logic [2:0]     exp_pos = 3'd0;
  logic [2:0]     exp_neg = 3'd1;
  logic           exp_gnd = 1'b0;
  logic           exp_uni = 1'b0;
  logic           exp_err = 1'b0;
  logic [RES-1:0] exp_data = '0;
  logic [6:0]     last_w = '0;
  int             last_n = 0;

  always @(negedge clk) if (!rst && done) done_cnt++;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference decode: {valid, gnd, pos[2:0], neg[2:0]}
  function automatic logic [7:0] ref_dec(input logic [6:0] w);
    logic       se, odd, com;
    logic [2:0] p, n;
    logic       ok, g;
    se  = w[6]; odd = w[5]; com = w[2];
    p   = {w[4:3], odd};
    ok  = 1'b1; g = 1'b0; n = 3'd0;
    if (!se) begin
      n = {w[4:3], !odd};
      if (com) ok = 1'b0;
    end else if (com) begin
      n = 3'd7;
      if (p == 3'd7) ok = 1'b0;
    end else begin
      g = 1'b1;
    end
    return {ok, g, p, n};
  endfunction

  task automatic apply_model();
    logic [7:0] d;
    exp_err = 1'b0;
    if (last_n >= 7) begin
      d = ref_dec(last_w);
      if (d[7]) begin
        exp_gnd = d[6]; exp_pos = d[5:3]; exp_neg = d[2:0]; exp_uni = last_w[1];
      end else begin
        exp_err = 1'b1;
      end
    end
    last_n = 0;
  endtask

  task automatic chk_cfg(input string req);
    chk(req, {gnd, uni, pos, neg}, {exp_gnd, exp_uni, exp_pos, exp_neg});
  endtask

  task automatic frame(input logic [6:0] w, input int n);
    if (cnv) begin
      cnv = 1'b0;
      nxt(2);
    end
    chk("R6 oe in frame", oe, 1);
    for (int i = 0; i < n; i++) begin
      chk("R6 sdo bit", sdo, exp_data[RES-1]);
      sdi = (i < 7) ? w[6-i] : 1'($urandom);
      sck = 1'b1;
      nxt(2);
      sck = 1'b0;
      nxt(2);
      exp_data = {exp_data[RES-2:0], 1'b0};
    end
    last_w = w;
    last_n = n;
  endtask

  task automatic convert(input logic [RES-1:0] smp, input bit short_p, input bit retrig);
    int k;
    int start_cnt;
    logic [6:0] w;
    w = last_w;
    sample = smp;
    cnv = 1'b1;
    start_cnt = done_cnt;
    chk_cfg("R7 not applied before rise");
    nxt(1);
    k = 1;
    apply_model();
    if (w[6]) chk_cfg("R9 single-ended decode");
    else      chk_cfg("R8 pair decode");
    chk("R10 cfg_err", cfg_err, exp_err);
    chk("R2 busy", busy, 1);
    if (short_p) cnv = 1'b0;
    if (retrig && !short_p) begin
      nxt(1);
      cnv = 1'b0;
      nxt(2);
      cnv = 1'b1;
      k = 4;
    end
    nxt(CONV - k);
    chk("R2 done early", done, 0);
    chk("R6 hiz during conversion", oe, 0);
    nxt(1);
    chk("R2 done on time", done, 1);
    if (short_p) begin
      chk("R5 oe at end", oe, 1);
      chk("R5 msb at end", sdo, smp[RES-1]);
      chk("R5 active", pwr, 0);
    end else begin
      chk("R4 oe at end", oe, 0);
      chk("R4 nap", pwr, 1);
    end
    exp_data = smp;
    if (retrig) begin
      nxt(CONV + 4);
      chk("R3 single done", done_cnt - start_cnt, 1);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int start_cnt;
    rst = 1'b1; cnv = 1'b1; sck = 1'b0; sdi = 1'b0; sample = '0;
    void'($urandom(32'd1234));
    nxt(4);
    rst = 1'b0;
    nxt(3);
    chk("R1 pwr", pwr, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 oe", oe, 0);
    chk("R1 cfg", {gnd, uni, pos, neg, cfg_err}, {1'b0, 1'b0, 3'd0, 3'd1, 1'b0});

    // directed decode and timing cases
    frame(7'b0_0_01_0_1_0, 16); convert(16'hA5C3, 0, 0);  // R8 pair 2/3
    frame(7'b0_1_11_0_0_0, 16); convert(16'h8001, 1, 0);  // R8 swapped 7/6, R5
    frame(7'b1_1_10_1_0_0, 16); convert(16'h7FFE, 0, 1);  // R9 ch5 vs ch7, R3
    frame(7'b1_1_11_1_0_0, 16); convert(16'h1234, 0, 0);  // R10 ch7 with common
    frame(7'b0_0_00_1_1_0, 16); convert(16'hFFFF, 1, 0);  // R10 pair with common
    frame(7'b1_0_11_0_1_0, 4);  convert(16'h0F0F, 0, 0);  // R7 partial word
    frame(7'b1_0_10_0_0_0, 16); convert(16'hC001, 0, 0);  // R9 ch4 vs ground

    // sleep entry
    frame(7'b1_0_00_0_0_1, 7);
    cnv = 1'b1; start_cnt = done_cnt;
    nxt(1);
    apply_model();
    chk("R11 sleep entered", pwr, 2);
    chk("R11 no busy", busy, 0);
    chk_cfg("R9 cfg with sleep word");
    nxt(CONV + 3);
    chk("R11 no conversion", done_cnt - start_cnt, 0);
    frame(7'b0_0_00_0_0_0, 3);
    cnv = 1'b1;
    nxt(1);
    apply_model();
    chk("R11 partial keeps sleep", pwr, 2);
    chk_cfg("R7 partial word in sleep");
    frame(7'b1_0_00_0_1_1, 7);
    cnv = 1'b1;
    nxt(1);
    apply_model();
    chk("R11 sleep word keeps sleep", pwr, 2);
    // wake
    frame(7'b1_1_01_0_1_0, 7);
    cnv = 1'b1;
    nxt(1);
    apply_model();
    chk("R12 waking", pwr, 3);
    chk_cfg("R9 cfg with wake word");
    nxt(1); cnv = 1'b0; nxt(2); cnv = 1'b1;
    nxt(WAKE - 4);
    chk("R12 still waking", pwr, 3);
    chk("R12 no busy while waking", busy, 0);
    nxt(1);
    chk("R12 nap after wake", pwr, 1);
    chk("R12 no conversion", done_cnt - start_cnt, 0);
    frame(7'b0_1_00_0_0_0, 16); convert(16'h5A5A, 1, 0);  // R12 converts after wake

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [6:0] w;
      int n;
      w = 7'($urandom) & 7'b1111110;
      n = (($urandom % 5) != 0) ? 16 : int'($urandom % 7);
      frame(w, n);
      convert(RES'($urandom), 1'($urandom), 1'b0);
    end

    nxt(4);
    finish_run();
  end

endmodule